// File: doc/BRIEF.md
# Clock Output Selector and Divider

This block produces one output clock from a choice of four free-running input clocks. Software picks the source and a divide ratio through three word registers on a plain synchronous register port. Changing the source is a two-step operation. The new selection is first staged in the select register. It reaches the output only when software arms the update register by writing a 0 and then a 1.

The switch-over between sources never produces a shortened pulse. The old clock is gated off on its own falling edge. The new clock is gated on, on its own falling edge, only after the old gate has closed. Each step passes through a two-flop chain. The gated clock then feeds a divider. A ratio of zero holds the output low. A ratio of N from 1 to 255 gives one output period per N source periods, and a new ratio is loaded only at an output period boundary.

Top module: `clkout_gen`

## Requirements
- R1: After reset all three registers read 0, the staged and active source is 0 (RC oscillator), and `clk_out` stays low.
- R2: The 2-bit source code maps 0 to `src_clk[0]` (RC oscillator), 1 to `src_clk[1]` (system oscillator), 2 to `src_clk[2]` (watchdog oscillator) and 3 to `src_clk[3]` (main clock).
- R3: A write to the select register (byte offset 0x0, bits 1:0) on its own leaves the output source unchanged.
- R4: The staged selection becomes active when bit 0 of the update register (offset 0x4) is written 1 while it holds 0. A write of 1 while it already holds 1 triggers nothing.
- R5: A divider value (offset 0x8, bits 7:0) of 0 keeps `clk_out` low with no edges.
- R6: For a divider value N of 2 or more, the output period is N source periods and the high phase lasts floor(N/2) source periods. For N = 1 the selected source clock passes through unchanged.
- R7: Register bits above bit 1 (select), bit 0 (update) and bit 7 (divider) read 0. Unmapped offsets read 0 and ignore writes.
- R8: At no time are two source gates open together.
- R9: A new divider value takes effect only at an output period boundary, so every high or low phase has either the old or the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| src_clk | input | 4 | Candidate source clocks, index equals source code |
| clk_out | output | 1 | Divided output clock |

## Verification
The assertions take the source clocks as free-running. They also assume that only one source change is in flight at a time, so a new arming write never comes before the previous hand-over has completed. The divider value is taken to stay stable for at least two cycles of the selected clock, because it crosses into that domain without a handshake. The stimulus follows these rules by waiting a fixed settling interval, longer than two periods of the slowest output, after every configuration change before it measures or changes anything else.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
  localparam int SEL_W = 2;
  localparam int N_SRC = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SRC_RC     = 2'd0,
    SRC_SYSOSC = 2'd1,
    SRC_WDOG   = 2'd2,
    SRC_MAIN   = 2'd3
  } src_id_e;

  localparam int OFF_SEL = 'h0;
  localparam int OFF_UPD = 'h4;
  localparam int OFF_DIV = 'h8;
endpackage

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  active_sel,
  output logic [DIV_W-1:0]  div_val
);
  logic [SEL_W-1:0] sel_q;
  logic             upd_q;
  logic             hit_sel, hit_upd, hit_div, arm;
  logic             unused_wbits;

  assign hit_sel = (addr == ADDR_W'(OFF_SEL));
  assign hit_upd = (addr == ADDR_W'(OFF_UPD));
  assign hit_div = (addr == ADDR_W'(OFF_DIV));
  // only a rising transition of the stored update bit arms a switch
  assign arm     = wr && hit_upd && wdata[0] && !upd_q;
  assign unused_wbits = ^wdata[DATA_W-1:DIV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= SRC_RC;
      upd_q      <= 1'b0;
      div_val    <= '0;
      active_sel <= SRC_RC;
    end else begin
      if (wr && hit_sel) sel_q   <= wdata[SEL_W-1:0];
      if (wr && hit_upd) upd_q   <= wdata[0];
      if (wr && hit_div) div_val <= wdata[DIV_W-1:0];
      if (arm)           active_sel <= sel_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_sel)      rdata[SEL_W-1:0] = sel_q;
    else if (hit_upd) rdata[0]         = upd_q;
    else if (hit_div) rdata[DIV_W-1:0] = div_val;
  end

  // R3: a select write alone never moves the active source
  p_sel_staged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_sel) |=> (active_sel == $past(active_sel)));

  // R4: the active source only changes right after an arming write
  p_arm_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_sel != $past(active_sel)) |-> $past(wr && hit_upd && wdata[0] && !upd_q));

  // R7: reserved select bits read zero
  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sel |-> (rdata[DATA_W-1:SEL_W] == '0));
endmodule

// File: rtl/clkout_gate_chan.sv
`timescale 1ns/1ps
module clkout_gate_chan (
  input  logic clk_src,
  input  logic rst_n,
  input  logic req,
  output logic en
);
  logic req_s1;

  // two-stage chain on the falling edge: the gate moves only while the clock is low
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      en     <= 1'b0;
    end else begin
      req_s1 <= req;
      en     <= req_s1;
    end
  end
endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider #(
  parameter int DIV_W = 8
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_in,
  output logic             clk_out
);
  logic [DIV_W-1:0] div_s1, div_s2;
  logic [DIV_W-1:0] cur_n, cnt;
  logic             div_q, pass_en, boundary;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      div_s1 <= '0;
      div_s2 <= '0;
    end else begin
      div_s1 <= div_in;
      div_s2 <= div_s1;
    end
  end

  assign boundary = (cur_n < DIV_W'(2)) || (cnt == cur_n - 1'b1);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cur_n <= '0;
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (boundary) begin
      cur_n <= div_s2;
      cnt   <= '0;
      div_q <= (div_s2 >= DIV_W'(2));
    end else begin
      cnt   <= cnt + 1'b1;
      div_q <= ((cnt + 1'b1) < (cur_n >> 1));
    end
  end

  // pass-through gate for ratio 1, opened and closed while the clock is low
  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) pass_en <= 1'b0;
    else        pass_en <= (cur_n == DIV_W'(1));
  end

  assign clk_out = (mclk & pass_en) | div_q;

  // R5: a zero ratio leaves the divided phase low
  p_zero_quiet_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    (cur_n == '0) |-> !div_q);

  // R6: the phase counter stays inside the active ratio
  p_cnt_range_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    (cur_n >= DIV_W'(2)) |-> (cnt < cur_n));

  // R9: the ratio only changes at the end of an output period
  p_load_boundary_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    (cur_n != $past(cur_n)) |->
      (($past(cur_n) < DIV_W'(2)) || ($past(cnt) == $past(cur_n) - 1'b1)));
endmodule

// File: rtl/clkout_gen.sv
`timescale 1ns/1ps
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  src_clk,
  output logic              clk_out
);
  logic [SEL_W-1:0] active_sel;
  logic [DIV_W-1:0] div_val;
  logic [N_SRC-1:0] chan_req, gate_en;
  logic             mclk;

  clkout_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .active_sel(active_sel),
    .div_val   (div_val)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_chan
    // a source may open only once every other gate reports closed
    assign chan_req[g] = (active_sel == SEL_W'(g)) &&
                         ((gate_en & ~(N_SRC'(1) << g)) == '0);
    clkout_gate_chan chan_i (
      .clk_src(src_clk[g]),
      .rst_n  (rst_n),
      .req    (chan_req[g]),
      .en     (gate_en[g])
    );
  end

  assign mclk = |(src_clk & gate_en);

  clkout_divider #(.DIV_W(DIV_W)) div_i (
    .mclk   (mclk),
    .rst_n  (rst_n),
    .div_in (div_val),
    .clk_out(clk_out)
  );

  // R8: never two source gates open together
  p_one_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en));
endmodule

// File: tb/clkout_gen_tb_top.sv
`timescale 1ns/1ps
module clkout_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE_NS  = 12000;
  localparam int WD_NS      = 2000000;
  localparam int N_VEC      = 7;
  // source code, ratio, expected period ns, expected high ns
  localparam int VEC [N_VEC][4] = '{
    '{0,   1,   14,    7},
    '{0,   2,   28,   14},
    '{1,   3,   66,   22},
    '{2,   4,  120,   60},
    '{3,   5,   90,   36},
    '{1, 255, 5610, 2794},
    '{3,   2,   36,   18}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  logic        clk_out;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #7  s0 = ~s0;
  always #11 s1 = ~s1;
  always #15 s2 = ~s2;
  always #9  s3 = ~s3;

  clkout_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_clk  ({s3, s2, s1, s0}),
    .clk_out  (clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic measure(output int hi, output int per);
    logic prev;
    int   t_rise, t_fall, st;
    #0.5;
    prev = clk_out; st = 0; hi = -1; per = -1; t_rise = 0; t_fall = 0;
    for (int k = 0; k < 40000; k++) begin
      #1;
      if (!prev && clk_out) begin
        if (st == 0) begin t_rise = k; st = 1; end
        else if (st == 2) begin per = k - t_rise; hi = t_fall - t_rise; break; end
      end else if (prev && !clk_out && st == 1) begin
        t_fall = k; st = 2;
      end
      prev = clk_out;
    end
  endtask

  task automatic count_edges(input int steps, output int n);
    logic prev;
    #0.5;
    prev = clk_out; n = 0;
    for (int k = 0; k < steps; k++) begin
      #1;
      if (clk_out != prev) n++;
      prev = clk_out;
    end
  endtask

  task automatic pulse_scan(input int steps, input int wa, input int wb,
                            output int bad, output int seen);
    logic prev;
    int   last;
    #0.5;
    prev = clk_out; last = -1; bad = 0; seen = 0;
    for (int k = 0; k < steps; k++) begin
      #1;
      if (clk_out != prev) begin
        if (last >= 0) begin
          seen++;
          if ((k - last) != wa && (k - last) != wb) bad++;
        end
        last = k;
      end
      prev = clk_out;
    end
  endtask

  initial begin
    #(WD_NS);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, hi, per, bad, seen;
    #(CLK_PERIOD*10);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(4'h0, v); check("R1 sel reset", v, 0);
    bus_read(4'h4, v); check("R1 upd reset", v, 0);
    bus_read(4'h8, v); check("R1 div reset", v, 0);
    count_edges(2000, v); check("R1 output quiet", v, 0);
    check("R1 output low", int'(clk_out), 0);

    // R2 R4 R6: table walk, each entry staged then armed with 0 then 1
    for (int i = 0; i < N_VEC; i++) begin
      bus_write(4'h8, 32'(VEC[i][1]));
      bus_write(4'h0, 32'(VEC[i][0]));
      bus_write(4'h4, 32'd0);
      bus_write(4'h4, 32'd1);
      #(SETTLE_NS);
      measure(hi, per);
      check($sformatf("R2 R6 period vec%0d", i), per, VEC[i][2]);
      check($sformatf("R6 high vec%0d", i), hi, VEC[i][3]);
    end

    // R3: staging source 0 alone keeps source 3 (ratio 2)
    bus_write(4'h0, 32'd0);
    #(SETTLE_NS);
    measure(hi, per); check("R3 staged only", per, 36);

    // R4: writing 1 over 1 does not re-trigger
    bus_write(4'h4, 32'd1);
    #(SETTLE_NS);
    measure(hi, per); check("R4 no retrigger", per, 36);
    bus_write(4'h4, 32'd0);
    #(SETTLE_NS);
    measure(hi, per); check("R4 zero write only", per, 36);
    bus_write(4'h4, 32'd1);
    #(SETTLE_NS);
    measure(hi, per); check("R4 armed switch", per, 28);

    // R9: ratio 2 -> 6 on source 0, every phase is 14 or 42 ns
    bus_write(4'h8, 32'd6);
    pulse_scan(1500, 14, 42, bad, seen);
    check("R9 runt phases", bad, 0);
    check("R9 phases seen", int'(seen > 10), 1);
    measure(hi, per); check("R9 new period", per, 84);

    // R5: ratio 0 silences the output
    bus_write(4'h8, 32'd0);
    #(SETTLE_NS);
    count_edges(2000, v); check("R5 no edges", v, 0);
    check("R5 output low", int'(clk_out), 0);

    // R7: reserved bits and unmapped offsets
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, v); check("R7 sel reserved", v, 3);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, v); check("R7 div reserved", v, 255);
    bus_write(4'h4, 32'd0);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, v); check("R7 upd reserved", v, 1);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'hC, v); check("R7 unmapped", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule